// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns characters waiting in an external transmit FIFO into asynchronous serial frames on one output line. The line rests at logic 1. When the FIFO reports data and the block is idle, it pops one character and sends a low start bit, then the character least significant bit first, then an optional parity bit, then a high stop period. Every bit time is measured in strobes of an external baud tick that runs at sixteen times the bit rate. The block has no divider of its own.

Run-time line-control inputs select the character length (5 to 8 bits), the stop length (1, 1.5 or 2 bit times), whether a parity bit is sent, and which kind of parity it carries. These inputs are captured when a character is loaded, so the frame on the line always matches the settings that were present at its start. When the FIFO still holds data as the stop period ends, the next character is popped on that same tick, and frames follow one another with no gap. A transmit-empty request output follows the FIFO empty flag so that an interrupt controller can refill the FIFO.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `txOut` is 1, `busy` is 0 and `fifoPop` is 0 while `fifoEmpty` is 1.
- R2: When idle and `fifoEmpty` is 0, `fifoPop` is 1 for exactly that cycle. From the next cycle the line is 0 (start bit) for 16 baud ticks.
- R3: After the start bit, the character is sent least significant bit first, 16 ticks per bit. The number of bits is 5 + `cfgLen` (`cfgLen` 0..3 gives 5..8 bits). Higher `fifoData` bits are not sent.
- R4: With `cfgParEn` = 1, exactly one 16-tick parity bit follows the last data bit. With `cfgParEn` = 0, the stop period follows the last data bit directly.
- R5: `cfgParType` = 0 gives even parity (the count of ones in the sent data bits plus the parity bit is even), 1 gives odd parity, 2 gives a constant 0 and 3 gives a constant 1.
- R6: The stop period is high for 16 ticks when `cfgStop` = 0, 24 ticks when it is 1, and 32 ticks when it is 2 or 3.
- R7: The configuration inputs are captured on the cycle `fifoPop` is 1. A change during a frame has no effect on the rest of that frame.
- R8: If `fifoEmpty` is 0 during the tick that ends the stop period, `fifoPop` is 1 in that same cycle and the next start bit begins at once, with no idle time.
- R9: `txEmptyReq` equals the value `fifoEmpty` had at the previous clock edge. It is 1 out of reset.
- R10: `busy` is 1 from the cycle after a pop until the cycle after the stop period ends.
- R11: `txOut` changes only at a clock edge where `baudTick` or `fifoPop` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| fifoEmpty | input | 1 | Transmit FIFO has no character |
| fifoData | input | DATA_W | Head character of the FIFO (show-ahead) |
| fifoPop | output | 1 | Consume the head character this cycle |
| cfgLen | input | 2 | Character length code, length = 5 + code |
| cfgStop | input | 2 | Stop length code: 0 one bit, 1 one and a half, 2/3 two |
| cfgParEn | input | 1 | Send a parity bit |
| cfgParType | input | 2 | 0 even, 1 odd, 2 constant 0, 3 constant 1 |
| txOut | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| txEmptyReq | output | 1 | Transmit-empty request |

## Verification
The bench uses the default parameters: 8-bit characters and 16 ticks per bit. These make every length, parity and stop code reachable, including the 24-tick stop. The baud tick is driven with spacings of one, two and three clocks. Spacing one places a tick on every clock edge, which reaches the zero-gap handover between frames. Wider spacings check that the line holds still between ticks. Configuration changes in the middle of a frame check that the settings captured at load are the ones used.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } txPhase_e;

  typedef enum logic [1:0] {
    LV_MARK,
    LV_SPACE,
    LV_DATA,
    LV_PAR
  } lineSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     advance;
    logic     shift;
    lineSel_e lineSel;
  } txStrobe_s;

  // conditions from datapath to control
  typedef struct packed {
    logic bitEnd;
    logic stopEnd;
    logic lastData;
    logic parOn;
  } txStatus_s;

  localparam logic [1:0] PAR_EVEN   = 2'd0;
  localparam logic [1:0] PAR_ODD    = 2'd1;
  localparam logic [1:0] PAR_STICK0 = 2'd2;

  localparam logic [1:0] STOP_ONE     = 2'd0;
  localparam logic [1:0] STOP_ONEHALF = 2'd1;

endpackage

// File: rtl/uft_datapath.sv
module uft_datapath
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEmpty,
  input  logic [1:0]        cfgLen,
  input  logic [1:0]        cfgStop,
  input  logic              cfgParEn,
  input  logic [1:0]        cfgParType,
  input  txStrobe_s         strobe,
  output txStatus_s         status,
  output logic              txOut,
  output logic              txEmptyReq
);

  localparam int IDX_W   = $clog2(DATA_W);
  localparam int CNT_W   = $clog2(2 * OVS);
  localparam int MIN_LEN = DATA_W - 3;
  localparam logic [CNT_W-1:0] BIT_LAST     = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] ONEHALF_LAST = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] TWO_LAST     = CNT_W'(2 * OVS - 1);

  logic [IDX_W-1:0]  lenLastIn, lenLastQ, bitIdx;
  logic [DATA_W-1:0] maskedData, shiftReg;
  logic [CNT_W-1:0]  tickCnt, stopLastIn, stopLastQ;
  logic              parBitIn, parBitQ, parOnQ, emptyQ;

  assign lenLastIn = IDX_W'(MIN_LEN - 1) + IDX_W'(cfgLen);

  // only the bits that will be sent take part in parity
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign maskedData[g] = fifoData[g] & (IDX_W'(g) <= lenLastIn);
  end

  always_comb begin
    case (cfgParType)
      PAR_EVEN:   parBitIn = ^maskedData;
      PAR_ODD:    parBitIn = ~^maskedData;
      PAR_STICK0: parBitIn = 1'b0;
      default:    parBitIn = 1'b1;
    endcase
  end

  always_comb begin
    case (cfgStop)
      STOP_ONE:     stopLastIn = BIT_LAST;
      STOP_ONEHALF: stopLastIn = ONEHALF_LAST;
      default:      stopLastIn = TWO_LAST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitIdx    <= '0;
      tickCnt   <= '0;
      lenLastQ  <= '0;
      stopLastQ <= '0;
      parOnQ    <= 1'b0;
      parBitQ   <= 1'b0;
      emptyQ    <= 1'b1;
    end else begin
      emptyQ <= fifoEmpty;
      if (strobe.load) begin
        shiftReg  <= fifoData;
        bitIdx    <= '0;
        tickCnt   <= '0;
        lenLastQ  <= lenLastIn;
        stopLastQ <= stopLastIn;
        parOnQ    <= cfgParEn;
        parBitQ   <= parBitIn;
      end else if (strobe.advance) begin
        tickCnt <= '0;
        if (strobe.shift) begin
          shiftReg <= shiftReg >> 1;
          bitIdx   <= bitIdx + 1'b1;
        end
      end else if (tick) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign status.bitEnd   = tick & (tickCnt == BIT_LAST);
  assign status.stopEnd  = tick & (tickCnt == stopLastQ);
  assign status.lastData = (bitIdx == lenLastQ);
  assign status.parOn    = parOnQ;

  always_comb begin
    case (strobe.lineSel)
      LV_SPACE: txOut = 1'b0;
      LV_DATA:  txOut = shiftReg[0];
      LV_PAR:   txOut = parBitQ;
      default:  txOut = 1'b1;
    endcase
  end

  assign txEmptyReq = emptyQ;

endmodule

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fifoEmpty,
  input  txStatus_s status,
  output txStrobe_s strobe,
  output logic      fifoPop,
  output logic      busy
);

  txPhase_e phase, phaseNxt;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  always_comb begin
    phaseNxt = phase;
    strobe   = '0;
    fifoPop  = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (!fifoEmpty) begin
          fifoPop     = 1'b1;
          strobe.load = 1'b1;
          phaseNxt    = PH_START;
        end
      end
      PH_START: begin
        strobe.lineSel = LV_SPACE;
        if (status.bitEnd) begin
          strobe.advance = 1'b1;
          phaseNxt       = PH_DATA;
        end
      end
      PH_DATA: begin
        strobe.lineSel = LV_DATA;
        if (status.bitEnd) begin
          strobe.advance = 1'b1;
          strobe.shift   = 1'b1;
          if (status.lastData) phaseNxt = status.parOn ? PH_PAR : PH_STOP;
        end
      end
      PH_PAR: begin
        strobe.lineSel = LV_PAR;
        if (status.bitEnd) begin
          strobe.advance = 1'b1;
          phaseNxt       = PH_STOP;
        end
      end
      PH_STOP: begin
        strobe.lineSel = LV_MARK;
        if (status.stopEnd) begin
          strobe.advance = 1'b1;
          if (!fifoEmpty) begin
            fifoPop     = 1'b1;
            strobe.load = 1'b1;
            phaseNxt    = PH_START;
          end else begin
            phaseNxt = PH_IDLE;
          end
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoPop,
  input  logic [1:0]        cfgLen,
  input  logic [1:0]        cfgStop,
  input  logic              cfgParEn,
  input  logic [1:0]        cfgParType,
  output logic              txOut,
  output logic              busy,
  output logic              txEmptyReq
);

  txStrobe_s strobe;
  txStatus_s status;

  uft_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fifoEmpty(fifoEmpty),
    .status   (status),
    .strobe   (strobe),
    .fifoPop  (fifoPop),
    .busy     (busy)
  );

  uft_datapath #(
    .DATA_W(DATA_W),
    .OVS   (OVS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (baudTick),
    .fifoData  (fifoData),
    .fifoEmpty (fifoEmpty),
    .cfgLen    (cfgLen),
    .cfgStop   (cfgStop),
    .cfgParEn  (cfgParEn),
    .cfgParType(cfgParType),
    .strobe    (strobe),
    .status    (status),
    .txOut     (txOut),
    .txEmptyReq(txEmptyReq)
  );

endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic fifoEmpty,
  input logic fifoPop,
  input logic txOut,
  input logic busy
);

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  p_pop_has_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  p_start_space_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txOut);

  p_pop_in_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPop && busy) |-> txOut);

  p_pop_then_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> (busy && !txOut));

  p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(baudTick) && !$past(fifoPop)) |-> $stable(txOut));

endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .baudTick (baudTick),
  .fifoEmpty(fifoEmpty),
  .fifoPop  (fifoPop),
  .txOut    (txOut),
  .busy     (busy)
);

// File: tb/serial_frame_tx_tb_top.sv
module serial_frame_tx_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, baudTick, fifoEmpty, fifoPop, cfgParEn, txOut, busy, txEmptyReq;
  logic [7:0] fifoData;
  logic [1:0] cfgLen, cfgStop, cfgParType;

  serial_frame_tx #(.DATA_W(8), .OVS(16)) dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .fifoEmpty(fifoEmpty),
    .fifoData(fifoData), .fifoPop(fifoPop), .cfgLen(cfgLen), .cfgStop(cfgStop),
    .cfgParEn(cfgParEn), .cfgParType(cfgParType), .txOut(txOut), .busy(busy),
    .txEmptyReq(txEmptyReq)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] fifoQ[$];
  int segLvl[$];
  int segLen[$];
  string segTag[$];
  bit active = 0;
  int rem = 0;
  bit lastEmpty = 1;
  int cyc = 0;
  int tickDiv = 3;
  string phaseTag = "";

  function automatic void refresh();
    fifoEmpty = (fifoQ.size() == 0);
    fifoData  = fifoEmpty ? 8'h00 : fifoQ[0];
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s%s %s act=%0d exp=%0d", tag, phaseTag, what, act, exp);
    end
  endtask

  function automatic int stopTicks(logic [1:0] s);
    if (s == 2'd0) return 16;
    if (s == 2'd1) return 24;
    return 32;
  endfunction

  // expected segments of one frame from the requirements
  function automatic void loadFrame(logic [7:0] d);
    int n = 5 + int'(cfgLen);
    int ones = 0;
    int pb;
    segLvl.push_back(0); segLen.push_back(16); segTag.push_back("R2");
    for (int i = 0; i < n; i++) begin
      segLvl.push_back(int'(d[i])); segLen.push_back(16); segTag.push_back("R3");
      ones += int'(d[i]);
    end
    if (cfgParEn) begin
      case (cfgParType)
        2'd0: pb = ones % 2;
        2'd1: pb = 1 - (ones % 2);
        2'd2: pb = 0;
        default: pb = 1;
      endcase
      segLvl.push_back(pb); segLen.push_back(16); segTag.push_back("R4/R5");
    end
    segLvl.push_back(1); segLen.push_back(stopTicks(cfgStop)); segTag.push_back("R6");
    active = 1;
    rem = 16;
  endfunction

  task automatic step();
    bit expPop, endNow, sawPop, wasEmpty;
    int expLine;
    string lineTag;
    logic [7:0] headData;
    @(negedge clk);
    baudTick = ((cyc % tickDiv) == 0);
    cyc++;
    #1;
    expLine = active ? segLvl[0] : 1;
    lineTag = active ? segTag[0] : "R1";
    endNow  = active && baudTick && rem == 1 && segLvl.size() == 1;
    expPop  = !fifoEmpty && (!active || endNow);
    chk(txOut === expLine[0], {lineTag, "/R11"}, "txOut", int'(txOut), expLine);
    chk(fifoPop === expPop, active ? "R8" : "R2", "fifoPop", int'(fifoPop), int'(expPop));
    chk(busy === active, "R10", "busy", int'(busy), int'(active));
    chk(txEmptyReq === lastEmpty, "R9", "txEmptyReq", int'(txEmptyReq), int'(lastEmpty));
    sawPop   = fifoPop;
    wasEmpty = fifoEmpty;
    headData = fifoData;
    @(posedge clk);
    #1;
    if (active && baudTick) begin
      rem--;
      if (rem == 0) begin
        void'(segLvl.pop_front()); void'(segLen.pop_front()); void'(segTag.pop_front());
        if (segLvl.size() > 0) rem = segLen[0];
        else active = 0;
      end
    end
    if (expPop) loadFrame(headData);
    lastEmpty = wasEmpty;
    if (sawPop && fifoQ.size() > 0) void'(fifoQ.pop_front());
    refresh();
  endtask

  task automatic waitIdle();
    int guard = 0;
    step();
    while ((fifoQ.size() > 0 || active) && guard < 30000) begin
      step();
      guard++;
    end
    repeat (3) step();
  endtask

  task automatic setCfg(logic [1:0] l, logic [1:0] s, logic pe, logic [1:0] pt);
    cfgLen = l; cfgStop = s; cfgParEn = pe; cfgParType = pt;
  endtask

  task automatic sendOne(logic [7:0] d);
    fifoQ.push_back(d);
    refresh();
    waitIdle();
  endtask

  initial begin
    #(4 * 195000);
    failures++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    baudTick = 1'b0;
    setCfg(2'd3, 2'd0, 1'b0, 2'd0);
    refresh();
    repeat (3) @(negedge clk);
    #1;
    // R1 / R9 reset state
    chk(txOut === 1'b1, "R1", "reset txOut", int'(txOut), 1);
    chk(busy === 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(fifoPop === 1'b0, "R1", "reset fifoPop", int'(fifoPop), 0);
    chk(txEmptyReq === 1'b1, "R9", "reset txEmptyReq", int'(txEmptyReq), 1);
    @(negedge clk);
    rstN = 1'b1;

    // R1 idle with ticks and no data
    tickDiv = 1;
    repeat (40) step();

    // R3 plain 8-bit frames
    tickDiv = 3;
    sendOne(8'hA5);
    sendOne(8'h3C);

    // R3 R4 R5 R6 every length, parity kind and stop code
    tickDiv = 2;
    for (int l = 0; l < 4; l++)
      for (int pt = 0; pt < 4; pt++)
        for (int s = 0; s < 3; s++) begin
          setCfg(2'(l), 2'(s), 1'b1, 2'(pt));
          sendOne(8'(8'h1D + l * 37 + pt * 11 + s * 3));
        end

    // R4 parity off, short characters whose upper bits must not appear
    for (int l = 0; l < 4; l++) begin
      setCfg(2'(l), 2'd1, 1'b0, 2'd0);
      sendOne(8'hE6 ^ 8'(l));
    end

    // R8 back to back with a tick on every clock
    tickDiv = 1;
    setCfg(2'd3, 2'd0, 1'b1, 2'd1);
    fifoQ.push_back(8'h81); fifoQ.push_back(8'h7E);
    fifoQ.push_back(8'h00); fifoQ.push_back(8'hFF);
    refresh();
    waitIdle();

    // R7 configuration changed while frames are in flight
    tickDiv = 2;
    phaseTag = " R7";
    setCfg(2'd3, 2'd0, 1'b0, 2'd0);
    fifoQ.push_back(8'h96); fifoQ.push_back(8'h4B);
    refresh();
    repeat (60) step();
    setCfg(2'd0, 2'd2, 1'b1, 2'd1);
    repeat (300) step();
    setCfg(2'd2, 2'd1, 1'b1, 2'd3);
    waitIdle();
    phaseTag = "";

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule